// File: doc/BRIEF.md
# Oversampled Receive Capture with Alternating Buffers

This block takes a demodulated receive bit stream that is sampled at four times the bit rate and turns it into 32-bit words in memory. Each sample arrives with a one-cycle enable. Samples are shifted in LSB first, and a word is written through a simple write port once all 32 samples are in. The write address comes from one of two buffer descriptors. The current descriptor receives words. The queued descriptor takes over the moment the current one is full.

A mode input selects how capture begins and ends:
- In the two framed modes, the block first hunts for a programmable 4-sample start pattern. It then records one frame of 16 words and goes back to hunting.
- In one-shot mode, capture starts at once and the receiver shuts off when the first buffer completes.
- In continuous mode, capture starts at once and runs until the mode changes.
- The off mode and the unused codes keep the receiver idle.

Status pulses report four events: a completed buffer, a completion that leaves no queued buffer, a word lost for lack of a buffer, and a start-pattern match. After a completion that leaves no buffer, the completion and loss pulses stay silent until an explicit unthrottle.

Top module: `pingpong_capture`

## Requirements
- R1: After reset, every output is low, both descriptors are empty, the receiver is disabled and the throttle is clear.
- R2: In modes 1 (short frame) and 2 (standard frame), capture begins only when the last four samples equal `sof_pat_i`, with the oldest of the four in bit 0. The match raises `cmp_o` for one cycle, one cycle after the matching sample.
- R3: Samples are packed LSB first: the first sample of a word lands in bit 0. `wr_en_o` pulses one cycle after the 32nd sample, with the address equal to the current base plus the index of the word within that buffer.
- R4: In the framed modes, a frame is exactly 16 words. After the 16th word the block hunts for the start pattern again, and no word is written until it matches.
- R5: In modes 3 (one-shot) and 4 (continuous), capture begins with the first sample after `start_i`, with no pattern search, and `cmp_o` never rises.
- R6: In mode 0, and for codes 5 to 7, no sample is consumed: nothing is written and no status pulse is raised, even with a loaded descriptor and `start_i`.
- R7: A loaded word count is limited to 511 in mode 4 and to 16 in every other mode. The limit is applied using the mode in force at load time. A count of zero marks the descriptor as empty, and no write is ever issued to it.
- R8: Storing the last word of the current buffer raises `done_o` in the same cycle as that write. The queued descriptor then becomes current, and the queued slot becomes empty.
- R9: If the queued descriptor is empty at a completion, `starve_o` pulses together with `done_o`, and both descriptors must be reloaded.
- R10: In mode 3 the receiver turns off when the first buffer completes. Further samples are ignored until the next `start_i`.
- R11: A word completed while the current descriptor is empty is dropped, and `ovr_o` pulses one cycle after its 32nd sample.
- R12: A `starve_o` event throttles the block. While it is throttled, `done_o`, `starve_o` and `ovr_o` are held low until `unthrottle_i` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_en_i | input | 1 | Sample valid strobe |
| smp_d_i | input | 1 | Sample value |
| mode_i | input | 3 | 0 off, 1 short frame, 2 standard frame, 3 one-shot, 4 continuous |
| sof_pat_i | input | 4 | Start pattern, oldest sample in bit 0 |
| start_i | input | 1 | Enable the receiver in the present mode |
| cur_ld_i | input | 1 | Load the current descriptor from ld_base_i and ld_cnt_i |
| nxt_ld_i | input | 1 | Load the queued descriptor from ld_base_i and ld_cnt_i |
| ld_base_i | input | 16 | Descriptor base word address |
| ld_cnt_i | input | 9 | Descriptor word count |
| unthrottle_i | input | 1 | Clear the status throttle |
| wr_en_o | output | 1 | Word write strobe |
| wr_addr_o | output | 16 | Word write address |
| wr_data_o | output | 32 | Word write data |
| done_o | output | 1 | Buffer complete pulse |
| starve_o | output | 1 | Completion with no queued buffer |
| ovr_o | output | 1 | Word dropped, no buffer |
| cmp_o | output | 1 | Start pattern matched |

## Verification
Every result is registered once behind the sampling edge:
- A write, `done_o`, `starve_o` and `ovr_o` appear in the cycle after the 32nd sample of a word.
- `cmp_o` appears in the cycle after the fourth pattern sample.
- A `start_i`, a load or a mode change takes effect on the sample driven in the following cycle.

The bench drives samples on the falling edge and logs the write port and every pulse on the falling edge. It compares the logs only after a few idle cycles, so each result is counted once, after the cycle in which it is due. The start pattern is swept over all sixteen values, and buffer hand-off, clamping, starvation and one-shot stop are each exercised with computed word values and addresses.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [2:0] {
    MODE_OFF     = 3'd0,
    MODE_SHORT   = 3'd1,
    MODE_STD     = 3'd2,
    MODE_ONESHOT = 3'd3,
    MODE_CONT    = 3'd4
  } cap_mode_e;

  function automatic logic mode_framed(logic [2:0] m);
    return (m == MODE_SHORT) || (m == MODE_STD);
  endfunction

  function automatic logic mode_live(logic [2:0] m);
    return (m >= MODE_SHORT) && (m <= MODE_CONT);
  endfunction
endpackage

// File: rtl/cap_sof_match.sv
module cap_sof_match #(
  parameter int SOF_LEN = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               en_i,
  input  logic               d_i,
  input  logic [SOF_LEN-1:0] pat_i,
  output logic               hit_o
);
  localparam int FW = $clog2(SOF_LEN + 1);
  localparam logic [FW-1:0] FULL = FW'(SOF_LEN - 1);

  logic [SOF_LEN-1:0] win_q, win_n;
  logic [FW-1:0]      fill_q;

  // newest sample enters the top, oldest sits in bit 0
  assign win_n = {d_i, win_q[SOF_LEN-1:1]};
  assign hit_o = en_i && (fill_q == FULL) && (win_n == pat_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (clr_i || hit_o) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (en_i) begin
      win_q <= win_n;
      if (fill_q != FULL) fill_q <= fill_q + 1'b1;
    end
  end
endmodule

// File: rtl/cap_packer.sv
module cap_packer #(
  parameter int SMP_PER_WORD = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    en_i,
  input  logic                    d_i,
  output logic                    word_vld_o,
  output logic [SMP_PER_WORD-1:0] word_o
);
  localparam int BW = $clog2(SMP_PER_WORD);
  localparam logic [BW-1:0] LAST = BW'(SMP_PER_WORD - 1);

  logic [SMP_PER_WORD-1:0] sh_q;
  logic [BW-1:0]           cnt_q;

  assign word_o     = {d_i, sh_q[SMP_PER_WORD-1:1]};
  assign word_vld_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (en_i) begin
      sh_q  <= word_o;
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cap_desc.sv
module cap_desc #(
  parameter int AW    = 16,
  parameter int CNT_W = 9,
  parameter int DW    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             word_vld_i,
  input  logic [DW-1:0]    word_i,
  input  logic             cur_ld_i,
  input  logic             nxt_ld_i,
  input  logic [AW-1:0]    base_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             unthrottle_i,
  output logic             fin_o,
  output logic             wr_en_o,
  output logic [AW-1:0]    wr_addr_o,
  output logic [DW-1:0]    wr_data_o,
  output logic             done_o,
  output logic             starve_o,
  output logic             ovr_o
);
  logic [AW-1:0]    cur_addr_q, nxt_addr_q;
  logic [CNT_W-1:0] cur_left_q, nxt_left_q;
  logic             thr_q;
  logic             store, drop, starve;

  assign store  = word_vld_i && (cur_left_q != '0);
  assign drop   = word_vld_i && (cur_left_q == '0);
  assign fin_o  = store && (cur_left_q == CNT_W'(1));
  assign starve = fin_o && (nxt_left_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o    <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
      done_o     <= 1'b0;
      starve_o   <= 1'b0;
      ovr_o      <= 1'b0;
      cur_addr_q <= '0;
      cur_left_q <= '0;
      nxt_addr_q <= '0;
      nxt_left_q <= '0;
      thr_q      <= 1'b0;
    end else begin
      wr_en_o  <= store;
      done_o   <= fin_o && !thr_q;
      starve_o <= starve && !thr_q;
      ovr_o    <= drop && !thr_q;
      if (store) begin
        wr_addr_o  <= cur_addr_q;
        wr_data_o  <= word_i;
        cur_addr_q <= cur_addr_q + 1'b1;
        cur_left_q <= cur_left_q - 1'b1;
      end
      // hand-off: queued slot becomes current
      if (fin_o) begin
        cur_addr_q <= nxt_addr_q;
        cur_left_q <= nxt_left_q;
        nxt_left_q <= '0;
      end
      if (starve)            thr_q <= 1'b1;
      else if (unthrottle_i) thr_q <= 1'b0;
      // loads in the same cycle override the promotion
      if (cur_ld_i) begin
        cur_addr_q <= base_i;
        cur_left_q <= cnt_i;
      end
      if (nxt_ld_i) begin
        nxt_addr_q <= base_i;
        nxt_left_q <= cnt_i;
      end
    end
  end
endmodule

// File: rtl/pingpong_capture.sv
module pingpong_capture
  import cap_pkg::*;
#(
  parameter int SMP_PER_WORD = 32,
  parameter int SOF_LEN      = 4,
  parameter int FRAME_WORDS  = 16,
  parameter int BUF_WORDS    = 16,
  parameter int CONT_WORDS   = 511,
  parameter int AW           = 16,
  parameter int CNT_W        = $clog2(CONT_WORDS + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    smp_en_i,
  input  logic                    smp_d_i,
  input  logic [2:0]              mode_i,
  input  logic [SOF_LEN-1:0]      sof_pat_i,
  input  logic                    start_i,
  input  logic                    cur_ld_i,
  input  logic                    nxt_ld_i,
  input  logic [AW-1:0]           ld_base_i,
  input  logic [CNT_W-1:0]        ld_cnt_i,
  input  logic                    unthrottle_i,
  output logic                    wr_en_o,
  output logic [AW-1:0]           wr_addr_o,
  output logic [SMP_PER_WORD-1:0] wr_data_o,
  output logic                    done_o,
  output logic                    starve_o,
  output logic                    ovr_o,
  output logic                    cmp_o
);
  localparam int FW = $clog2(FRAME_WORDS + 1);
  localparam logic [FW-1:0]    FRM_LAST  = FW'(FRAME_WORDS - 1);
  localparam logic [CNT_W-1:0] LIM_CONT  = CNT_W'(CONT_WORDS);
  localparam logic [CNT_W-1:0] LIM_FRAME = CNT_W'(BUF_WORDS);

  logic [2:0]              mode_q;
  logic                    rx_en_q, capt_q;
  logic [FW-1:0]           frm_q;
  logic                    mode_chg, framed, active;
  logic                    pk_en, hunt_en, hit, frm_last;
  logic                    word_vld, fin;
  logic [SMP_PER_WORD-1:0] word;
  logic [CNT_W-1:0]        lim, ld_eff;

  assign mode_chg = (mode_i != mode_q);
  assign framed   = mode_framed(mode_q);
  assign active   = rx_en_q && mode_live(mode_q) && !mode_chg;
  assign pk_en    = smp_en_i && active && (capt_q || !framed);
  assign hunt_en  = smp_en_i && active && framed && !capt_q;
  assign frm_last = word_vld && framed && (frm_q == FRM_LAST);
  assign lim      = (mode_q == MODE_CONT) ? LIM_CONT : LIM_FRAME;
  assign ld_eff   = (ld_cnt_i > lim) ? lim : ld_cnt_i;

  cap_sof_match #(.SOF_LEN(SOF_LEN)) u_sof (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!active || capt_q),
    .en_i   (hunt_en),
    .d_i    (smp_d_i),
    .pat_i  (sof_pat_i),
    .hit_o  (hit)
  );

  cap_packer #(.SMP_PER_WORD(SMP_PER_WORD)) u_pack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (!(active && (capt_q || !framed))),
    .en_i       (pk_en),
    .d_i        (smp_d_i),
    .word_vld_o (word_vld),
    .word_o     (word)
  );

  cap_desc #(.AW(AW), .CNT_W(CNT_W), .DW(SMP_PER_WORD)) u_desc (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .word_vld_i   (word_vld),
    .word_i       (word),
    .cur_ld_i     (cur_ld_i),
    .nxt_ld_i     (nxt_ld_i),
    .base_i       (ld_base_i),
    .cnt_i        (ld_eff),
    .unthrottle_i (unthrottle_i),
    .fin_o        (fin),
    .wr_en_o      (wr_en_o),
    .wr_addr_o    (wr_addr_o),
    .wr_data_o    (wr_data_o),
    .done_o       (done_o),
    .starve_o     (starve_o),
    .ovr_o        (ovr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_OFF;
      rx_en_q <= 1'b0;
      capt_q  <= 1'b0;
      frm_q   <= '0;
      cmp_o   <= 1'b0;
    end else begin
      mode_q <= mode_i;
      cmp_o  <= hit;
      if (mode_chg)                          rx_en_q <= 1'b0;
      else if (fin && mode_q == MODE_ONESHOT) rx_en_q <= 1'b0;
      else if (start_i)                      rx_en_q <= 1'b1;
      if (!active || hit) begin
        capt_q <= hit;
        frm_q  <= '0;
      end else if (word_vld && framed) begin
        frm_q <= frm_last ? '0 : frm_q + 1'b1;
        if (frm_last) capt_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pingpong_capture_chk.sv
module pingpong_capture_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] mode_i,
  input logic       wr_en_o,
  input logic       done_o,
  input logic       ovr_o,
  input logic       cmp_o
);
  // R11: a dropped word is never also written
  assert_ovr_no_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |-> !wr_en_o);

  // R8: completion coincides with the final write of the buffer
  assert_done_with_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> wr_en_o);

  // R6: a settled off mode issues no writes
  assert_off_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd0 && $past(mode_i) == 3'd0) |=> !wr_en_o);

  // R5: continuous mode never reports a pattern match
  assert_cont_no_cmp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd4 && $past(mode_i) == 3'd4) |=> !cmp_o);

  // R10: one-shot completion is followed by no further write
  assert_oneshot_stop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(mode_i, 2) == 3'd3) |=> !wr_en_o);
endmodule

bind pingpong_capture pingpong_capture_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .mode_i  (mode_i),
  .wr_en_o (wr_en_o),
  .done_o  (done_o),
  .ovr_o   (ovr_o),
  .cmp_o   (cmp_o)
);

// File: tb/pingpong_capture_tb.sv
module pingpong_capture_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_en = 1'b0, smp_d = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [3:0]  pat = 4'd1;
  logic        start = 1'b0, cur_ld = 1'b0, nxt_ld = 1'b0, unthr = 1'b0;
  logic [15:0] ld_base = '0;
  logic [8:0]  ld_cnt = '0;
  logic        wr_en, done, starve, ovr, cmp;
  logic [15:0] wr_addr;
  logic [31:0] wr_data;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int nwr = 0, n_done = 0, n_starve = 0, n_ovr = 0, n_cmp = 0;
  logic [15:0] log_a [0:2047];
  logic [31:0] log_d [0:2047];

  always #5 clk = ~clk;

  pingpong_capture u_dut (
    .clk_i(clk), .rst_ni(rst_n), .smp_en_i(smp_en), .smp_d_i(smp_d),
    .mode_i(mode), .sof_pat_i(pat), .start_i(start), .cur_ld_i(cur_ld),
    .nxt_ld_i(nxt_ld), .ld_base_i(ld_base), .ld_cnt_i(ld_cnt),
    .unthrottle_i(unthr), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .done_o(done), .starve_o(starve), .ovr_o(ovr),
    .cmp_o(cmp)
  );

  always @(negedge clk) if (rst_n) begin
    if (wr_en) begin
      if (nwr < 2048) begin
        log_a[nwr] = wr_addr;
        log_d[nwr] = wr_data;
      end
      nwr++;
    end
    if (done)   n_done++;
    if (starve) n_starve++;
    if (ovr)    n_ovr++;
    if (cmp)    n_cmp++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<190000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [31:0] wv(int n);
    return (32'(n) * 32'h9E3779B1) ^ 32'h5A5A0F0F ^ (32'(n) << 7);
  endfunction

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic smp(logic d);
    @(negedge clk); smp_en = 1'b1; smp_d = d;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(negedge clk); smp_en = 1'b0; end
  endtask

  task automatic send_word(logic [31:0] w);
    for (int b = 0; b < 32; b++) smp(w[b]);
  endtask

  task automatic send_pat(logic [3:0] p);
    for (int b = 0; b < 4; b++) smp(p[b]);
  endtask

  task automatic pulse_start();
    @(negedge clk); smp_en = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic pulse_unthr();
    @(negedge clk); smp_en = 1'b0; unthr = 1'b1;
    @(negedge clk); unthr = 1'b0;
  endtask

  task automatic load(logic nxt, logic [15:0] b, logic [8:0] c);
    @(negedge clk); smp_en = 1'b0; ld_base = b; ld_cnt = c;
    cur_ld = !nxt; nxt_ld = nxt;
    @(negedge clk); cur_ld = 1'b0; nxt_ld = 1'b0;
  endtask

  task automatic set_mode(logic [2:0] m);
    @(negedge clk); smp_en = 1'b0; mode = m;
    idle(2);
  endtask

  task automatic check_wr(string req, int first, int n, int base, int seed);
    for (int k = 0; k < n; k++) begin
      chk(req, log_a[first+k], base + k);
      chk(req, log_d[first+k], wv(seed + k));
    end
  endtask

  int w0, d0, s0, o0, c0;
  task automatic snap();
    w0 = nwr; d0 = n_done; s0 = n_starve; o0 = n_ovr; c0 = n_cmp;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    chk("R1 wr_en", wr_en, 0); chk("R1 done", done, 0);
    chk("R1 starve", starve, 0); chk("R1 ovr", ovr, 0); chk("R1 cmp", cmp, 0);

    // framed short mode, pattern 0x1
    set_mode(3'd1); pat = 4'h1;
    load(1'b0, 16'h0100, 9'd16); load(1'b1, 16'h0200, 9'd16);
    pulse_start(); snap();
    for (int i = 0; i < 10; i++) send_pat(4'b0110);
    idle(3);
    chk("R2 no match cmp", n_cmp - c0, 0); chk("R2 no match write", nwr - w0, 0);
    send_pat(4'h1);
    for (int k = 0; k < 16; k++) send_word(wv(k));
    idle(3);
    chk("R2 cmp", n_cmp - c0, 1);
    chk("R3 count", nwr - w0, 16);
    check_wr("R3 word", w0, 16, 16'h0100, 0);
    chk("R8 done", n_done - d0, 1); chk("R9 no starve", n_starve - s0, 0);
    snap();
    send_word(32'h0); idle(3);
    chk("R4 hunt after frame", nwr - w0, 0);
    send_pat(4'h1);
    for (int k = 0; k < 16; k++) send_word(wv(100 + k));
    idle(3);
    chk("R4 second frame", nwr - w0, 16);
    check_wr("R8 promoted", w0, 16, 16'h0200, 100);
    chk("R8 done", n_done - d0, 1); chk("R9 starve", n_starve - s0, 1);

    // throttled, no descriptors
    snap();
    send_pat(4'h1);
    for (int k = 0; k < 16; k++) send_word(wv(200 + k));
    idle(3);
    chk("R12 ovr masked", n_ovr - o0, 0); chk("R12 no write", nwr - w0, 0);
    pulse_unthr(); snap();
    send_pat(4'h1);
    for (int k = 0; k < 16; k++) send_word(wv(300 + k));
    idle(3);
    chk("R11 ovr", n_ovr - o0, 16); chk("R11 no write", nwr - w0, 0);

    // continuous
    set_mode(3'd4); pulse_unthr();
    load(1'b0, 16'h1000, 9'd511); load(1'b1, 16'h1400, 9'd3);
    pulse_start(); snap();
    for (int k = 0; k < 514; k++) send_word(wv(2000 + k));
    idle(3);
    chk("R7 cont count", nwr - w0, 514);
    check_wr("R7 cont buf", w0, 511, 16'h1000, 2000);
    check_wr("R8 cont next", w0 + 511, 3, 16'h1400, 2511);
    chk("R8 cont done", n_done - d0, 2); chk("R9 cont starve", n_starve - s0, 1);
    chk("R5 cont no cmp", n_cmp - c0, 0);

    // one-shot with clamped count
    set_mode(3'd3); pulse_unthr();
    load(1'b0, 16'h0300, 9'd40); load(1'b1, 16'h0340, 9'd4);
    pulse_start(); snap();
    for (int k = 0; k < 18; k++) send_word(wv(3000 + k));
    idle(3);
    chk("R10 stop count", nwr - w0, 16);
    check_wr("R7 clamp", w0, 16, 16'h0300, 3000);
    chk("R10 no ovr", n_ovr - o0, 0); chk("R10 done", n_done - d0, 1);
    chk("R5 oneshot no cmp", n_cmp - c0, 0);
    pulse_start(); snap();
    for (int k = 0; k < 4; k++) send_word(wv(3100 + k));
    idle(3);
    chk("R10 restart", nwr - w0, 4);
    check_wr("R8 oneshot next", w0, 4, 16'h0340, 3100);
    chk("R9 oneshot starve", n_starve - s0, 1);

    // zero-count descriptor
    set_mode(3'd4); pulse_unthr();
    load(1'b0, 16'h0500, 9'd0);
    pulse_start(); snap();
    send_word(wv(3500)); idle(3);
    chk("R7 zero count", nwr - w0, 0); chk("R11 zero ovr", n_ovr - o0, 1);

    // off mode
    set_mode(3'd0);
    load(1'b0, 16'h0600, 9'd4);
    pulse_start(); snap();
    send_word(wv(3600)); send_word(wv(3601)); idle(3);
    chk("R6 off write", nwr - w0, 0); chk("R6 off ovr", n_ovr - o0, 0);
    set_mode(3'd4); pulse_start(); snap();
    send_word(wv(4000)); idle(3);
    chk("R6 later write", nwr - w0, 1);
    check_wr("R6 descriptor kept", w0, 1, 16'h0600, 4000);

    // sweep every start pattern in standard mode
    for (int p = 0; p < 16; p++) begin
      set_mode(3'd0); set_mode(3'd2); pat = 4'(p);
      pulse_unthr();
      load(1'b0, 16'(16'h0400 + p), 9'd1);
      pulse_start(); snap();
      send_pat(4'(p));
      send_word(wv(5000 + p));
      idle(3);
      chk("R2 sweep cmp", n_cmp - c0, 1);
      chk("R2 sweep write", nwr - w0, 1);
      check_wr("R3 sweep word", w0, 1, 16'h0400 + p, 5000 + p);
      chk("R9 sweep starve", n_starve - s0, 1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule